// File: doc/BRIEF.md
# Reduced-Power Mode Sequencer

This block controls power states for a small microcontroller. Software asks for a mode with a 3-bit code and a one-cycle strobe. The sequencer then turns off the core clock, main oscillator, PLL, internal RC oscillator output, RC oscillator supply, flash supply and main power domain. Which of these it turns off depends on the mode: sleep, deep-sleep, power-down or deep power-down. A short entry window comes before each mode. A wake event that arrives inside this window cancels the entry, so no wake is lost.

When a request is accepted, the block latches a wake mask. The mask holds the interrupts that are enabled and whose priority value is below a programmable threshold. The deeper modes use only this latched mask to decide on a wake, so changes to the enables after entry have no effect. The RTC alarm wakes the block from every mode. Leaving power-down or deep power-down needs the flash to come back. The block waits for the flash-ready input, with a cycle-count limit. If the limit runs out, the block returns to run anyway and raises an error flag. The block does not contain the analog supplies, the interrupt controller or the RTC counter. It sees them only through its ports.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, ready is 1. Core clock, main oscillator, RC output, RC supply, flash supply and main domain enables are 1. pll_en and clk_src_pll are 0.
- R2: Sleep (code 1) turns off only the core clock. The oscillators, PLL state, flash and domain keep their run values.
- R3: Deep-sleep (code 2) turns off the core clock, main oscillator, PLL and RC output. The RC supply, flash supply and main domain stay on.
- R4: Power-down (code 3) also removes the RC supply and the flash supply. Only the main domain stays on.
- R5: Deep power-down (code 4) turns off every output enable, including the main domain. It is accepted only when req_rtc is 1.
- R6: The block ignores a request with code 0 or codes 5 to 7, a code 4 request without req_rtc, and any request made outside run. For each of these, req_err is 1 for the single cycle after the strobe and the outputs do not change.
- R7: In deep-sleep and power-down, only interrupts in the mask latched at acceptance cause a wake. The mask holds irq_en bits whose 3-bit priority field is below prio_thresh. Changing irq_en after entry has no effect.
- R8: In sleep, any pending interrupt with its enable set causes a wake, whatever its priority.
- R9: rtc_alarm wakes the block from every reduced-power mode. Deep power-down ignores interrupts and wakes only on rtc_alarm.
- R10: A wake condition for the target mode during the entry window cancels entry and returns the block to run.
- R11: After a wake from power-down or deep power-down, ready stays 0 until flash_ready is seen. If FLASH_TMO cycles pass without it, the block returns to run with flash_err set. The next accepted request clears flash_err.
- R12: A clk_sel_main strobe in run sets clk_src_pll. pll_en is 1 only when clk_src_pll is 1 and the main oscillator is on. Entering deep-sleep, power-down or deep power-down clears clk_src_pll, so the block wakes on the RC oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_code | input | 3 | Requested mode: 0 run, 1 sleep, 2 deep-sleep, 3 power-down, 4 deep power-down |
| req_rtc | input | 1 | Request issued from the RTC side |
| clk_sel_main | input | 1 | Software switches to the PLL clock |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Interrupt enables |
| irq_prio | input | N_IRQ*PRIO_W | Packed priority fields, lower value more urgent |
| prio_thresh | input | PRIO_W | Priority threshold for the wake mask |
| rtc_alarm | input | 1 | RTC alarm match |
| flash_ready | input | 1 | Flash powered up and readable |
| core_clk_en | output | 1 | Core clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable and connection |
| irc_out_en | output | 1 | RC oscillator output enable |
| irc_pwr_en | output | 1 | RC oscillator supply |
| flash_pwr_en | output | 1 | Flash supply |
| main_pwr_en | output | 1 | Main power domain supply |
| clk_src_pll | output | 1 | 1 when the core runs from the PLL, 0 when it runs from the RC oscillator |
| ready | output | 1 | Block is in run |
| req_err | output | 1 | Last request was rejected |
| flash_err | output | 1 | Flash-ready wait timed out |

## Verification
The bench targets the corner cases where a faulty sequencer would behave wrongly in a way that is easy to miss:
- An interrupt that is enabled only after entry, or whose priority is above the threshold. A design that reads live enables would wake on it.
- A wake that arrives inside the entry window. A design without cancel would sleep through it.
- A deep power-down request without the RTC flag. A design that accepts it would drop the main domain.
- Flash that never reports ready. A design without the limit would hang, and one that skips the wait would show ready with flash off.
- The PLL source after a deep mode. A design that keeps it would wake with a stopped PLL still selected.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_ENTRY, ST_SLEEP, ST_DSLEEP, ST_PDOWN, ST_DPD, ST_FWAIT
  } lpm_state_e;

  localparam logic [2:0] MODE_RUN    = 3'd0;
  localparam logic [2:0] MODE_SLEEP  = 3'd1;
  localparam logic [2:0] MODE_DSLEEP = 3'd2;
  localparam logic [2:0] MODE_PDOWN  = 3'd3;
  localparam logic [2:0] MODE_DPD    = 3'd4;
endpackage

// File: rtl/lpm_req_check.sv
module lpm_req_check
  import lpm_pkg::*;
(
  input  logic       req_valid,
  input  logic [2:0] req_code,
  input  logic       req_rtc,
  input  logic       in_run,
  output logic       accept,
  output logic       reject
);
  logic legal;

  always_comb begin
    case (req_code)
      MODE_SLEEP, MODE_DSLEEP, MODE_PDOWN: legal = 1'b1;
      MODE_DPD:                            legal = req_rtc;
      default:                             legal = 1'b0;
    endcase
    accept = req_valid && in_run && legal;
    reject = req_valid && !accept;
  end
endmodule

// File: rtl/lpm_wake_mask.sv
module lpm_wake_mask #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [N_IRQ-1:0]        irq_pend,
  input  logic [N_IRQ-1:0]        irq_en,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]       prio_thresh,
  output logic [N_IRQ-1:0]        mask_q,
  output logic                    hit_masked,
  output logic                    hit_enabled
);
  logic [N_IRQ-1:0] eligible;
  logic [N_IRQ-1:0] mask_d;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_elig
    assign eligible[i] = irq_en[i] && (irq_prio[i*PRIO_W +: PRIO_W] < prio_thresh);
  end

  always_comb begin
    mask_d = mask_q;
    if (capture) mask_d = eligible;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign hit_masked  = |(irq_pend & mask_q);
  assign hit_enabled = |(irq_pend & irq_en);
endmodule

// File: rtl/lpm_flash_wait.sv
module lpm_flash_wait #(
  parameter int FLASH_TMO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic flash_ready,
  output logic done,
  output logic expired
);
  localparam int CW = $clog2(FLASH_TMO + 1);
  localparam logic [CW-1:0] LAST = CW'(FLASH_TMO - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (active && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    else if (active)             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done    = active && flash_ready;
  assign expired = active && !flash_ready && (cnt_q == LAST);

  // R11: the wait counter stays inside its window
  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int N_IRQ        = 8,
  parameter int PRIO_W       = 3,
  parameter int ENTRY_CYCLES = 2,
  parameter int FLASH_TMO    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [2:0]              req_code,
  input  logic                    req_rtc,
  input  logic                    clk_sel_main,
  input  logic [N_IRQ-1:0]        irq_pend,
  input  logic [N_IRQ-1:0]        irq_en,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]       prio_thresh,
  input  logic                    rtc_alarm,
  input  logic                    flash_ready,
  output logic                    core_clk_en,
  output logic                    main_osc_en,
  output logic                    pll_en,
  output logic                    irc_out_en,
  output logic                    irc_pwr_en,
  output logic                    flash_pwr_en,
  output logic                    main_pwr_en,
  output logic                    clk_src_pll,
  output logic                    ready,
  output logic                    req_err,
  output logic                    flash_err
);
  localparam int EW = $clog2(ENTRY_CYCLES + 1);
  localparam logic [EW-1:0] ENT_LAST = EW'(ENTRY_CYCLES - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  lpm_state_e    state_q, state_d;
  logic [2:0]    tgt_q, tgt_d;
  logic [EW-1:0] ent_q, ent_d;
  logic          src_q, src_d;
  logic          ferr_q, ferr_d;
  logic          rerr_q;
  logic          accept, reject;
  logic [N_IRQ-1:0] mask_q;
  logic          hit_masked, hit_enabled;
  logic          fw_done, fw_expired;
  logic          wake_tgt;

  lpm_req_check u_req (
    .req_valid (req_valid),
    .req_code  (req_code),
    .req_rtc   (req_rtc),
    .in_run    (state_q == ST_RUN),
    .accept    (accept),
    .reject    (reject)
  );

  lpm_wake_mask #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_mask (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .capture     (accept),
    .irq_pend    (irq_pend),
    .irq_en      (irq_en),
    .irq_prio    (irq_prio),
    .prio_thresh (prio_thresh),
    .mask_q      (mask_q),
    .hit_masked  (hit_masked),
    .hit_enabled (hit_enabled)
  );

  lpm_flash_wait #(.FLASH_TMO(FLASH_TMO)) u_fwait (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .active      (state_q == ST_FWAIT),
    .flash_ready (flash_ready),
    .done        (fw_done),
    .expired     (fw_expired)
  );

  // wake sources depend on the mode being entered or held
  always_comb begin
    case (tgt_q)
      MODE_SLEEP:             wake_tgt = hit_enabled || rtc_alarm;
      MODE_DSLEEP, MODE_PDOWN: wake_tgt = hit_masked || rtc_alarm;
      MODE_DPD:               wake_tgt = rtc_alarm;
      default:                wake_tgt = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    ent_d   = ent_q;
    src_d   = src_q;
    ferr_d  = ferr_q;
    case (state_q)
      ST_RUN: begin
        if (clk_sel_main) src_d = 1'b1;
        if (accept) begin
          state_d = ST_ENTRY;
          tgt_d   = req_code;
          ent_d   = '0;
          ferr_d  = 1'b0;
        end
      end
      ST_ENTRY: begin
        if (wake_tgt) begin
          state_d = ST_RUN;
        end else if (ent_q == ENT_LAST) begin
          case (tgt_q)
            MODE_SLEEP:  state_d = ST_SLEEP;
            MODE_DSLEEP: state_d = ST_DSLEEP;
            MODE_PDOWN:  state_d = ST_PDOWN;
            default:     state_d = ST_DPD;
          endcase
          if (tgt_q != MODE_SLEEP) src_d = 1'b0;
        end else begin
          ent_d = ent_q + 1'b1;
        end
      end
      ST_SLEEP, ST_DSLEEP: if (wake_tgt) state_d = ST_RUN;
      ST_PDOWN, ST_DPD:    if (wake_tgt) state_d = ST_FWAIT;
      ST_FWAIT: begin
        if (fw_done) begin
          state_d = ST_RUN;
        end else if (fw_expired) begin
          state_d = ST_RUN;
          ferr_d  = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_RUN;
      tgt_q   <= MODE_RUN;
      ent_q   <= '0;
      src_q   <= 1'b0;
      ferr_q  <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) tgt_q <= tgt_d;
      ent_q   <= ent_d;
      src_q   <= src_d;
      ferr_q  <= ferr_d;
      rerr_q  <= reject;
    end
  end

  logic clocks_on;
  assign clocks_on    = (state_q == ST_RUN) || (state_q == ST_ENTRY) ||
                        (state_q == ST_SLEEP) || (state_q == ST_FWAIT);
  assign core_clk_en  = (state_q == ST_RUN);
  assign main_osc_en  = clocks_on;
  assign pll_en       = clocks_on && src_q;
  assign irc_out_en   = clocks_on;
  assign irc_pwr_en   = !((state_q == ST_PDOWN) || (state_q == ST_DPD));
  assign flash_pwr_en = !((state_q == ST_PDOWN) || (state_q == ST_DPD));
  assign main_pwr_en  = (state_q != ST_DPD);
  assign clk_src_pll  = src_q;
  assign ready        = (state_q == ST_RUN);
  assign req_err      = rerr_q;
  assign flash_err    = ferr_q;

  // R6: a rejected request made in run leaves the block in run
  assert_reject_stays_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_err && $past(state_q) == ST_RUN) |-> state_q == ST_RUN);

  // R7: deep-sleep holds while no latched interrupt and no alarm
  assert_mask_only_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_DSLEEP && !rtc_alarm && !(|(irq_pend & mask_q))) |=> state_q == ST_DSLEEP);

  // R9: deep power-down leaves only on the RTC alarm
  assert_dpd_rtc_only_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_DPD && !rtc_alarm) |=> state_q == ST_DPD);

  // R11: leaving the flash wait needs ready or a timeout flag
  assert_flash_before_ready_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($rose(ready) && $past(state_q) == ST_FWAIT) |-> ($past(flash_ready) || flash_err));

  // R3: a running core always has flash and domain power
  assert_core_needs_flash_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    core_clk_en |-> (flash_pwr_en && main_pwr_en));

  // R12: the PLL never runs without its reference oscillator
  assert_pll_needs_osc_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    pll_en |-> main_osc_en);
endmodule

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;
  localparam int N_IRQ     = 8;
  localparam int PRIO_W    = 3;
  localparam int FLASH_TMO = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_rtc, clk_sel_main, rtc_alarm, flash_ready;
  logic [2:0] req_code;
  logic [N_IRQ-1:0] irq_pend, irq_en;
  logic [N_IRQ*PRIO_W-1:0] irq_prio;
  logic [PRIO_W-1:0] prio_thresh;
  logic core_clk_en, main_osc_en, pll_en, irc_out_en, irc_pwr_en, flash_pwr_en, main_pwr_en;
  logic clk_src_pll, ready, req_err, flash_err;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  lpm_sequencer #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ENTRY_CYCLES(2), .FLASH_TMO(FLASH_TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code), .req_rtc(req_rtc),
    .clk_sel_main(clk_sel_main), .irq_pend(irq_pend), .irq_en(irq_en), .irq_prio(irq_prio),
    .prio_thresh(prio_thresh), .rtc_alarm(rtc_alarm), .flash_ready(flash_ready),
    .core_clk_en(core_clk_en), .main_osc_en(main_osc_en), .pll_en(pll_en),
    .irc_out_en(irc_out_en), .irc_pwr_en(irc_pwr_en), .flash_pwr_en(flash_pwr_en),
    .main_pwr_en(main_pwr_en), .clk_src_pll(clk_src_pll), .ready(ready),
    .req_err(req_err), .flash_err(flash_err)
  );

  // {core, osc, pll, irc_out, irc_pwr, flash, domain}
  function automatic logic [6:0] pat();
    return {core_clk_en, main_osc_en, pll_en, irc_out_en, irc_pwr_en, flash_pwr_en, main_pwr_en};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(input logic [2:0] code, input logic rtc);
    @(negedge clk);
    req_valid = 1'b1; req_code = code; req_rtc = rtc;
    @(negedge clk);
    req_valid = 1'b0; req_rtc = 1'b0;
  endtask

  task automatic alarm();
    @(negedge clk); rtc_alarm = 1'b1;
    @(negedge clk); rtc_alarm = 1'b0;
  endtask

  // {code[2:0], rtc, pattern[6:0], req_err, accepted}
  localparam int NV = 9;
  localparam logic [12:0] VEC [NV] = '{
    {3'd1, 1'b0, 7'b0101111, 1'b0, 1'b1},  // R2 sleep
    {3'd2, 1'b0, 7'b0000111, 1'b0, 1'b1},  // R3 deep-sleep
    {3'd3, 1'b0, 7'b0000001, 1'b0, 1'b1},  // R4 power-down
    {3'd4, 1'b1, 7'b0000000, 1'b0, 1'b1},  // R5 deep power-down from RTC side
    {3'd4, 1'b0, 7'b1101111, 1'b1, 1'b0},  // R5 without RTC flag
    {3'd0, 1'b0, 7'b1101111, 1'b1, 1'b0},  // R6 run code
    {3'd5, 1'b0, 7'b1101111, 1'b1, 1'b0},  // R6 undefined
    {3'd7, 1'b1, 7'b1101111, 1'b1, 1'b0},  // R6 undefined
    {3'd1, 1'b1, 7'b0101111, 1'b0, 1'b1}   // R2 RTC flag irrelevant
  };

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_code = '0; req_rtc = 1'b0; clk_sel_main = 1'b0;
    irq_pend = '0; irq_en = '0; irq_prio = '0; prio_thresh = 3'd4;
    rtc_alarm = 1'b0; flash_ready = 1'b1;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);

    check("R1 reset enables", pat(), 7'b1101111);
    check("R1 reset ready", ready, 1);
    check("R1 reset clk src", clk_src_pll, 0);

    for (int v = 0; v < NV; v++) begin
      request(VEC[v][12:10], VEC[v][9]);
      check("R5/R6 req_err", req_err, VEC[v][1]);
      cycles(3);
      check("R2-R6 mode enables", pat(), VEC[v][8:2]);
      if (VEC[v][0]) begin
        check("R9 not ready in mode", ready, 0);
        alarm();
        cycles(2);
        check("R9 alarm wake ready", ready, 1);
        check("R9 run enables", pat(), 7'b1101111);
      end
    end

    // R7: latched mask, priority threshold 4
    irq_en = 8'b0000_0011;
    irq_prio[0*PRIO_W +: PRIO_W] = 3'd2;
    irq_prio[1*PRIO_W +: PRIO_W] = 3'd6;
    irq_prio[2*PRIO_W +: PRIO_W] = 3'd0;
    request(3'd2, 1'b0);
    cycles(3);
    irq_pend[1] = 1'b1;
    cycles(3);
    check("R7 low-priority irq ignored", ready, 0);
    irq_en[2] = 1'b1; irq_pend[2] = 1'b1;
    cycles(3);
    check("R7 late-enabled irq ignored", ready, 0);
    irq_pend[0] = 1'b1;
    cycles(2);
    check("R7 masked irq wakes", ready, 1);
    irq_pend = '0; irq_en = 8'b0000_0011;

    // R8: sleep wakes on any enabled irq, not on a disabled one
    request(3'd1, 1'b0);
    cycles(3);
    irq_pend[5] = 1'b1;
    cycles(3);
    check("R8 disabled irq ignored", ready, 0);
    irq_pend[1] = 1'b1;
    cycles(2);
    check("R8 enabled low-priority irq wakes", ready, 1);
    irq_pend = '0;

    // R9: deep power-down ignores interrupts
    request(3'd4, 1'b1);
    cycles(3);
    irq_pend[0] = 1'b1;
    cycles(3);
    check("R9 dpd ignores irq", pat(), 7'b0000000);
    irq_pend = '0;
    alarm();
    cycles(2);
    check("R9 dpd alarm wake", ready, 1);

    // R10: wake during entry window
    request(3'd2, 1'b0);
    irq_pend[0] = 1'b1;
    cycles(3);
    check("R10 entry aborted", ready, 1);
    check("R10 entry aborted enables", pat(), 7'b1101111);
    irq_pend = '0;

    // R6: request outside run
    request(3'd1, 1'b0);
    cycles(3);
    request(3'd2, 1'b0);
    check("R6 request in sleep flagged", req_err, 1);
    cycles(2);
    check("R6 request in sleep ignored", pat(), 7'b0101111);
    alarm();
    cycles(2);

    // R11: flash wait, late ready
    flash_ready = 1'b0;
    request(3'd3, 1'b0);
    cycles(3);
    alarm();
    cycles(4);
    check("R11 waiting for flash", ready, 0);
    flash_ready = 1'b1;
    cycles(2);
    check("R11 ready after flash", ready, 1);
    check("R11 no timeout flag", flash_err, 0);

    // R11: flash timeout
    flash_ready = 1'b0;
    request(3'd3, 1'b0);
    cycles(3);
    alarm();
    cycles(FLASH_TMO + 3);
    check("R11 timeout returns to run", ready, 1);
    check("R11 timeout flag", flash_err, 1);
    flash_ready = 1'b1;
    request(3'd1, 1'b0);
    check("R11 flag cleared by request", flash_err, 0);
    cycles(3);
    alarm();
    cycles(2);

    // R12: clock source handling
    @(negedge clk); clk_sel_main = 1'b1;
    @(negedge clk); clk_sel_main = 1'b0;
    check("R12 pll selected", {clk_src_pll, pll_en}, 2'b11);
    request(3'd1, 1'b0);
    cycles(3);
    check("R12 pll kept in sleep", pat(), 7'b0111111);
    alarm();
    cycles(2);
    request(3'd2, 1'b0);
    cycles(3);
    check("R12 pll off in deep-sleep", {clk_src_pll, pll_en}, 2'b00);
    alarm();
    cycles(2);
    check("R12 wake on RC clock", {clk_src_pll, pll_en, ready}, 3'b001);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule